// File: doc/BRIEF.md
# Dual-Channel Sine Tone PWM Generator

This block produces two sine tones by direct digital synthesis and drives each one out as an 8-bit pulse-width-modulated pin. The signalling channel gives a steady, sub-audible tone. The beep channel gives a tone that is scaled by a volume setting and can switch itself off after a set number of sample ticks. Both channels share one 256-entry sine table, one PWM counter and one sample tick.

The host works out each channel's 32-bit phase increment in 16.16 fixed point. One table period stands for 35 Hz, so the increment for a tone of f Hz is f·65536/35. The host then raises one-cycle on or off requests. A lock input reserves the beep pin for another user: while it is high, beep requests are refused and the beep duty stops following the tick. When neither channel is on, the whole generator stops and clears, so a new start always begins from a known phase of the counters. With default parameters at 84 MHz, the sample tick runs at about 8.96 kHz and the PWM carrier at 109.375 kHz.

Top module: `tone_pwm_gen`

## Requirements
- R1: Table entry i (0..255) lies within one count of floor(128 + 127.5·sin(2πi/256)). On each tick a channel's new sample is read at index bits [23:16] of its accumulator after that tick's addition.
- R2: Each channel has a 32-bit accumulator. It wraps modulo 2^32, adds the channel's increment once per tick, and is cleared by an accepted on request for that channel.
- R3: While the generator runs, a tick occurs every TICK_DIV clocks. The first tick comes TICK_DIV clocks after the edge that started an idle generator.
- R4: The 8-bit PWM counter advances once every PWM_DIV clocks and wraps after 255. A pin is high while its channel is on and the counter is below that channel's active duty. Otherwise the pin is low.
- R5: Each tick writes a pending duty. The active duty takes the pending value only at the edge where the counter leaves 255, so one PWM period always shows a single duty.
- R6: The beep duty is (sample × volume) >> 8, using the volume captured at the accepted beep on request.
- R7: An accepted beep on request loads the duration counter. Each tick decrements a nonzero count, and when the count goes from 1 to 0 the beep channel switches off. A loaded duration of 0 means the beep runs until it is turned off. A beep on request in the same cycle as the expiring tick wins and reloads the count.
- R8: While the lock is high, beep on and beep off requests are ignored and ticks do not update the beep's pending duty.
- R9: With both channels off, the prescaler, PWM counter, tick counter and all duty registers are held at zero.
- R10: The busy output equals the beep channel enable. For either channel, an off request in the same cycle as an on request wins.
- R11: After reset both pins and busy are low and both channels are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_on | input | 1 | One-cycle request to start the signalling tone |
| sig_off | input | 1 | One-cycle request to stop the signalling tone |
| sig_inc | input | 32 | Signalling phase increment, 16.16 fixed point |
| beep_on | input | 1 | One-cycle request to start a beep |
| beep_off | input | 1 | One-cycle request to stop the beep |
| beep_inc | input | 32 | Beep phase increment, 16.16 fixed point |
| beep_vol | input | 8 | Beep volume, captured on start |
| beep_ticks | input | CNT_W | Beep duration in ticks, 0 for no limit |
| beep_lock | input | 1 | Reserve the beep channel: refuse requests and freeze its duty |
| sig_pwm | output | 1 | Signalling PWM pin |
| beep_pwm | output | 1 | Beep PWM pin |
| beep_busy | output | 1 | Beep channel enabled |

## Verification
Two beep functions can fall in the same cycle: the tick that takes the duration count from 1 to 0, and a fresh beep on request. The bench starts a two-tick beep and waits for the edge where the expiring tick lands. It raises a new request exactly on that edge. It then judges the outcome by the busy output. Busy must stay high, and it must drop only one full duration later, which shows that the reload took priority and the count restarted. A second overlap, the sample tick landing on a PWM period boundary, is provoked by a tick divider that is not a multiple of 256. It is judged by requiring each measured period to show one whole table value.

// File: rtl/tone_pwm_gen.sv
`timescale 1ns/1ps
module tone_pwm_gen #(
  parameter int TICK_DIV = 9375,
  parameter int PWM_DIV  = 3,
  parameter int CNT_W    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_on,
  input  logic             sig_off,
  input  logic [31:0]      sig_inc,
  input  logic             beep_on,
  input  logic             beep_off,
  input  logic [31:0]      beep_inc,
  input  logic [7:0]       beep_vol,
  input  logic [CNT_W-1:0] beep_ticks,
  input  logic             beep_lock,
  output logic             sig_pwm,
  output logic             beep_pwm,
  output logic             beep_busy
);
  localparam int  PD_W    = $clog2(PWM_DIV + 1);
  localparam int  TD_W    = $clog2(TICK_DIV + 1);
  localparam longint PI_Q28 = 843314857;

  function automatic logic [2047:0] build_sine();
    logic [2047:0] t;
    longint x, term, sum, v;
    int q, sg;
    t = '0;
    for (int i = 0; i < 256; i++) begin
      q  = i % 128;
      if (q > 64) q = 128 - q;
      sg = (i < 128) ? 1 : -1;
      x    = (longint'(q) * PI_Q28) / 128;
      term = x;
      sum  = x;
      for (int k = 1; k <= 7; k++) begin
        term = -((((term * x) >>> 28) * x) >>> 28) / (2 * k * (2 * k + 1));
        sum  = sum + term;
      end
      v = ((longint'(256) <<< 28) + 255 * sg * sum) >>> 29;
      t[i*8 +: 8] = 8'(v);
    end
    return t;
  endfunction

  localparam logic [2047:0] SINE_TBL = build_sine();

  logic             sig_en, beep_en, run;
  logic [PD_W-1:0]  pre_q;
  logic [7:0]       pwm_q;
  logic [TD_W-1:0]  tick_q;
  logic [31:0]      acc_s, acc_b, acc_s_n, acc_b_n;
  logic [7:0]       samp_s, samp_b, vol_q;
  logic [15:0]      prod;
  logic [7:0]       next_s, next_b, act_s, act_b;
  logic [CNT_W-1:0] left_q;
  logic             pre_wrap, period_end, tick, beep_go, beep_stop;

  assign run        = sig_en | beep_en;
  assign pre_wrap   = (pre_q == PD_W'(PWM_DIV - 1));
  assign period_end = pre_wrap && (pwm_q == 8'hFF);
  assign tick       = run && (tick_q == TD_W'(TICK_DIV - 1));
  assign beep_go    = beep_on & ~beep_off & ~beep_lock;
  assign beep_stop  = beep_off & ~beep_lock;

  assign acc_s_n = acc_s + sig_inc;
  assign acc_b_n = acc_b + beep_inc;
  assign samp_s  = SINE_TBL[{acc_s_n[23:16], 3'b000} +: 8];
  assign samp_b  = SINE_TBL[{acc_b_n[23:16], 3'b000} +: 8];
  assign prod    = {8'd0, samp_b} * {8'd0, vol_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sig_en  <= 1'b0;
      beep_en <= 1'b0;
      acc_s   <= '0;
      acc_b   <= '0;
      vol_q   <= '0;
      left_q  <= '0;
    end else begin
      if (sig_off)      sig_en <= 1'b0;
      else if (sig_on)  sig_en <= 1'b1;
      if (sig_on && !sig_off) acc_s <= '0;
      else if (tick)          acc_s <= acc_s_n;

      if (beep_stop) begin
        beep_en <= 1'b0;
        left_q  <= '0;
      end else if (beep_go) begin
        beep_en <= 1'b1;
        left_q  <= beep_ticks;
        vol_q   <= beep_vol;
      end else if (tick && left_q != '0) begin
        left_q <= left_q - CNT_W'(1);
        if (left_q == CNT_W'(1)) beep_en <= 1'b0;
      end
      if (beep_go)   acc_b <= '0;
      else if (tick) acc_b <= acc_b_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      pre_q  <= '0;
      pwm_q  <= '0;
      tick_q <= '0;
      next_s <= '0;
      next_b <= '0;
      act_s  <= '0;
      act_b  <= '0;
    end else begin
      pre_q  <= pre_wrap ? '0 : pre_q + PD_W'(1);
      if (pre_wrap) pwm_q <= pwm_q + 8'd1;
      tick_q <= tick ? '0 : tick_q + TD_W'(1);
      if (tick) begin
        next_s <= samp_s;
        if (!beep_lock) next_b <= 8'(prod >> 8);
      end
      if (period_end) begin
        act_s <= next_s;
        act_b <= next_b;
      end
    end
  end

  assign sig_pwm   = sig_en && (pwm_q < act_s);
  assign beep_pwm  = beep_en && (pwm_q < act_b);
  assign beep_busy = beep_en;
endmodule

// File: rtl/tone_pwm_gen_chk.sv
`timescale 1ns/1ps
module tone_pwm_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       beep_on,
  input logic       beep_lock,
  input logic       beep_busy,
  input logic       tick,
  input logic       left_is_one,
  input logic       period_end,
  input logic       run,
  input logic       counters_zero,
  input logic [7:0] act_s,
  input logic [7:0] act_b
);
  a_r8_lock_blocks_on: assert property (@(posedge clk) disable iff (!rst_n)
    beep_lock && !beep_busy |=> !beep_busy);

  a_r8_lock_blocks_off: assert property (@(posedge clk) disable iff (!rst_n)
    beep_lock && beep_busy && !(tick && left_is_one) |=> beep_busy);

  a_r7_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    beep_busy && tick && left_is_one && !(beep_on && !beep_lock) |=> !beep_busy);

  a_r10_busy_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(beep_busy) |-> $past(beep_on && !beep_lock));

  a_r5_preload: assert property (@(posedge clk) disable iff (!rst_n)
    run && !period_end |=> $stable(act_s) && $stable(act_b));

  a_r9_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> counters_zero && act_s == 8'd0 && act_b == 8'd0);
endmodule

bind tone_pwm_gen tone_pwm_gen_chk chk (
  .clk(clk),
  .rst_n(rst_n),
  .beep_on(beep_on),
  .beep_lock(beep_lock),
  .beep_busy(beep_busy),
  .tick(tick),
  .left_is_one(left_q == CNT_W'(1)),
  .period_end(period_end),
  .run(run),
  .counters_zero(pwm_q == 8'd0 && tick_q == '0 && pre_q == '0),
  .act_s(act_s),
  .act_b(act_b)
);

// File: tb/tone_pwm_gen_test.sv
`timescale 1ns/1ps
module tone_pwm_gen_test;
  localparam int TD = 640;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic sig_on = 0, sig_off = 0, beep_on = 0, beep_off = 0, beep_lock = 0;
  logic [31:0] sig_inc = '0, beep_inc = '0, beep_ticks = '0;
  logic [7:0]  beep_vol = '0;
  logic sig_pwm, beep_pwm, beep_busy;

  tone_pwm_gen #(.TICK_DIV(TD), .PWM_DIV(1), .CNT_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .sig_on(sig_on), .sig_off(sig_off), .sig_inc(sig_inc),
    .beep_on(beep_on), .beep_off(beep_off), .beep_inc(beep_inc), .beep_vol(beep_vol),
    .beep_ticks(beep_ticks), .beep_lock(beep_lock),
    .sig_pwm(sig_pwm), .beep_pwm(beep_pwm), .beep_busy(beep_busy));

  // {sig_inc, beep_inc, volume}
  localparam logic [71:0] VEC [4] = '{
    {32'h0001_0000, 32'h0002_0000, 8'd255},
    {32'h0010_0000, 32'h0004_8000, 8'd128},
    {32'h0040_0000, 32'h00C0_0000, 8'd64},
    {32'hFFFF_0000, 32'h0100_0000, 8'd0}
  };

  int checks = 0, errors = 0;

  function automatic int sine_ref(int i);
    real v;
    v = 128.0 + 127.5 * $sin(2.0 * 3.14159265358979 * i / 256.0);
    return int'($floor(v));
  endfunction

  task automatic check_near(string tag, int act, int exp);
    checks++;
    if (act - exp > 1 || exp - act > 1) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic window(output int hs, output int hb);
    hs = 0; hb = 0;
    repeat (256) begin
      @(negedge clk);
      hs += int'(sig_pwm);
      hb += int'(beep_pwm);
    end
  endtask

  function automatic int exp_sample(int w, logic [31:0] inc);
    int m;
    logic [31:0] a;
    if (w == 0) return 0;
    m = (256 * w - 1) / TD;
    if (m == 0) return 0;
    a = inc * 32'(m);
    return sine_ref(int'(a[23:16]));
  endfunction

  task automatic stop_all();
    @(negedge clk); sig_off = 1; beep_off = 1;
    @(posedge clk); #1 sig_off = 0; beep_off = 0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hs, hb, es, eb, h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_eq("R11 sig_pwm reset", int'(sig_pwm), 0);
    check_eq("R11 beep_pwm reset", int'(beep_pwm), 0);
    check_eq("R11 busy reset", int'(beep_busy), 0);
    rst_n = 1;

    for (int v = 0; v < 4; v++) begin
      @(negedge clk);
      sig_inc = VEC[v][71:40]; beep_inc = VEC[v][39:8]; beep_vol = VEC[v][7:0];
      beep_ticks = 0; sig_on = 1; beep_on = 1;
      @(posedge clk); #1 sig_on = 0; beep_on = 0;
      for (int w = 0; w < 10; w++) begin
        window(hs, hb);
        es = exp_sample(w, VEC[v][71:40]);
        eb = (exp_sample(w, VEC[v][39:8]) * int'(VEC[v][7:0])) >> 8;
        check_near("R1_R2_R3_R4_R5 signalling duty", hs, es);
        check_near("R6 beep duty", hb, eb);
      end
      stop_all();
      @(negedge clk);
      check_eq("R9 sig low when idle", int'(sig_pwm), 0);
      check_eq("R9 beep low when idle", int'(beep_pwm), 0);
      check_eq("R10 busy follows beep off", int'(beep_busy), 0);
    end

    // R7 auto-off after three ticks
    @(negedge clk); beep_inc = 32'h0001_0000; beep_vol = 8'd200; beep_ticks = 3; beep_on = 1;
    @(posedge clk); #1 beep_on = 0;
    repeat (3 * TD - 1) @(posedge clk);
    @(negedge clk); check_eq("R7 busy before expiry", int'(beep_busy), 1);
    @(negedge clk); check_eq("R7 busy after expiry", int'(beep_busy), 0);
    check_eq("R7 beep pin after expiry", int'(beep_pwm), 0);

    // R7 collision: new request on the expiring tick
    @(negedge clk); beep_ticks = 2; beep_on = 1;
    @(posedge clk); #1 beep_on = 0;
    repeat (2 * TD - 1) @(posedge clk);
    @(negedge clk); beep_on = 1;
    @(posedge clk); #1 beep_on = 0;
    @(negedge clk); check_eq("R7 reload wins over expiry", int'(beep_busy), 1);
    repeat (2 * TD - 1) @(posedge clk);
    @(negedge clk); check_eq("R7 reloaded beep still on", int'(beep_busy), 1);
    @(negedge clk); check_eq("R7 reloaded beep expires", int'(beep_busy), 0);

    // R7 zero duration is unlimited
    @(negedge clk); beep_ticks = 0; beep_on = 1;
    @(posedge clk); #1 beep_on = 0;
    repeat (5 * TD) @(posedge clk);
    @(negedge clk); check_eq("R7 zero duration keeps running", int'(beep_busy), 1);
    stop_all();

    // R10 off wins over on in the same cycle
    @(negedge clk); beep_on = 1; beep_off = 1;
    @(posedge clk); #1 beep_on = 0; beep_off = 0;
    @(negedge clk); check_eq("R10 off beats on", int'(beep_busy), 0);

    // R8 lock refuses start
    @(negedge clk); beep_lock = 1; beep_on = 1;
    @(posedge clk); #1 beep_on = 0;
    window(hs, hb);
    check_eq("R8 locked start ignored busy", int'(beep_busy), 0);
    check_eq("R8 locked start ignored pin", hb, 0);

    // R8 lock freezes duty and refuses stop
    @(negedge clk); beep_lock = 0; beep_inc = 32'h0008_0000; beep_vol = 8'd255; beep_on = 1;
    @(posedge clk); #1 beep_on = 0;
    repeat (6) window(hs, hb);
    @(negedge clk); beep_lock = 1; beep_off = 1;
    @(posedge clk); #1 beep_off = 0;
    @(negedge clk); check_eq("R8 locked stop ignored", int'(beep_busy), 1);
    repeat (2) window(hs, hb);
    window(hs, h0);
    for (int k = 0; k < 3; k++) begin
      window(hs, hb);
      check_eq("R8 beep duty frozen under lock", hb, h0);
    end
    @(negedge clk); beep_lock = 0;
    stop_all();
    @(negedge clk); check_eq("R10 busy cleared after unlock", int'(beep_busy), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule